// File: doc/BRIEF.md
# Descriptor-Ring Transmit/Receive DMA Engine

This block moves packets between a word-addressed memory and two byte streams by walking two circular lists of descriptors, one for transmit and one for receive. Every descriptor takes four consecutive 32-bit words. Software places the first descriptor at a base address, states how many descriptors the list holds, and hands each descriptor to the engine by setting its ownership bit. A write to a per-direction kick register then starts the engine polling.

The transmit side reads each descriptor it owns, streams the referenced buffer out one byte per handshake, returns the descriptor to software, and moves on to the next one. The receive side takes the buffer address from each descriptor it owns and fills that buffer from the incoming byte stream. At the end of the frame it writes a status word back into the descriptor. When either side reaches a descriptor that software still owns, it parks, raises a buffer-unavailable flag and stays parked until software writes that side's kick register again. A status register, cleared by writing ones, collects completion and suspend events and drives a level interrupt.

Top module: `dma_ring_engine`

## Requirements
- R1: After reset the status register reads 0, `irq` is low, `tx_valid` is low and `rx_ready` is low.
- R2: Descriptor i of a list starts at word address base + 4*i. The ring-size register holds the descriptor count minus one, and after the descriptor whose index equals that value the engine goes back to index 0.
- R3: For a transmit descriptor it owns (word 3 bit 31 set), the engine sends the byte count from word 2 bits [13:0], taken from the buffer at the word address in word 0. Bytes go out lowest byte lane first within each word, in order, and `tx_last` is high on the final byte only.
- R4: After sending, the engine writes transmit word 3 back with bit 31 cleared and every other bit unchanged, so the first (bit 29) and last (bit 28) flags are kept.
- R5: Transmit-complete status (bit 0) is set after a descriptor finishes only if word 2 bit 31 (interrupt on completion) was set.
- R6: A descriptor found with bit 31 of word 3 clear is not processed. The engine stops and sets status bit 1 (transmit) or bit 3 (receive).
- R7: A stopped side does not restart by itself, even after software sets the ownership bit. A write of any value to its kick register (offset 2 for transmit, 5 for receive) makes it re-read the same descriptor.
- R8: On receive, bytes are packed lowest lane first into consecutive buffer words, and a partial last word is zero-filled. At frame end word 3 is written as bit 31 = 0, bit 29 = 1, bit 28 = 1, bit 15 = error and bits [13:0] = stored length, and status bit 2 is set.
- R9: Bytes of a frame beyond the buffer size register (offset 7, in bytes) are discarded and no memory past the buffer is written. The stored length equals the buffer size and the error bit 15 is set.
- R10: Status bits are cleared by writing 1 to them (offset 6). Setting a completion bit also sets summary bit 4, and `irq` follows bit 4.
- R11: `rx_ready` is high only while the receive side holds an owned buffer and is accepting bytes.
- R12: While `tx_valid` is high and `tx_ready` low, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset: 0 tx base, 1 tx ring size-1, 2 tx kick, 3 rx base, 4 rx ring size-1, 5 rx kick, 6 status, 7 rx buffer bytes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| irq | output | 1 | Interrupt, equal to status summary bit |
| txm_req | output | 1 | Transmit-side memory request |
| txm_we | output | 1 | Transmit-side memory write enable |
| txm_addr | output | ADDR_W | Transmit-side word address |
| txm_wdata | output | 32 | Transmit-side write data |
| txm_rdata | input | 32 | Transmit-side read data, one cycle after a read request |
| rxm_req | output | 1 | Receive-side memory request |
| rxm_we | output | 1 | Receive-side memory write enable |
| rxm_addr | output | ADDR_W | Receive-side word address |
| rxm_wdata | output | 32 | Receive-side write data |
| rxm_rdata | input | 32 | Receive-side read data, one cycle after a read request |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing byte accepted |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the outgoing frame |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Engine can take an incoming byte |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Final byte of the incoming frame |

## Verification
The bench builds the engine with ADDR_W = 12, IDX_W = 3 and LEN_W = 14. The address width matches a 4096-word memory array, and the index width leaves room for a four-entry transmit ring and a two-entry receive ring. Under these settings a short run walks a whole ring, wraps back to descriptor 0 and then meets a returned descriptor there, so wrap and suspend are both seen in one run. A six-byte receive buffer puts truncation, a zero-filled partial word and an untouched word just past the buffer within reach of a nine-byte frame. The ready pattern on the transmit stream stalls inside words and at word boundaries.

// File: rtl/dma_ring_pkg.sv
`timescale 1ns/1ps
package dma_ring_pkg;
  // descriptor bit positions
  localparam int OWN_BIT = 31;
  localparam int FIRST_BIT = 29;
  localparam int LAST_BIT = 28;
  localparam int IOC_BIT = 31;
  localparam int ERR_BIT = 15;

  // register offsets
  localparam logic [2:0] REG_TX_BASE = 3'd0;
  localparam logic [2:0] REG_TX_SIZE = 3'd1;
  localparam logic [2:0] REG_TX_KICK = 3'd2;
  localparam logic [2:0] REG_RX_BASE = 3'd3;
  localparam logic [2:0] REG_RX_SIZE = 3'd4;
  localparam logic [2:0] REG_RX_KICK = 3'd5;
  localparam logic [2:0] REG_STATUS  = 3'd6;
  localparam logic [2:0] REG_RX_BUF  = 3'd7;

  // status bits
  localparam int ST_W    = 5;
  localparam int ST_TXC  = 0;
  localparam int ST_TXBU = 1;
  localparam int ST_RXC  = 2;
  localparam int ST_RXBU = 3;
  localparam int ST_SUM  = 4;

  typedef enum logic [3:0] {
    T_IDLE, T_RD3, T_CK3, T_CK0, T_CK2, T_RDB, T_CKB, T_SEND, T_WB
  } tx_st_t;

  typedef enum logic [2:0] {
    R_IDLE, R_RD3, R_CK3, R_CK0, R_RECV, R_WR, R_WB
  } rx_st_t;
endpackage

// File: rtl/dma_ring_index.sv
`timescale 1ns/1ps
module dma_ring_index #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] desc_addr
);
  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else if (adv) idx <= (idx >= last_idx) ? '0 : idx + IDX_W'(1);
  end

  assign desc_addr = base + ADDR_W'({idx, 2'b00});

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && idx == last_idx) |=> (idx == '0));
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && idx < last_idx) |=> (idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/dma_ring_regs.sv
`timescale 1ns/1ps
module dma_ring_regs
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 8,
  parameter int LEN_W   = 14,
  parameter int DEF_BUF = 1536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [ADDR_W-1:0] tx_base,
  output logic [IDX_W-1:0]  tx_size,
  output logic              tx_kick,
  output logic [ADDR_W-1:0] rx_base,
  output logic [IDX_W-1:0]  rx_size,
  output logic              rx_kick,
  output logic [LEN_W-1:0]  rx_buf,
  input  logic              tx_done_i,
  input  logic              tx_bu_i,
  input  logic              rx_done_i,
  input  logic              rx_bu_i,
  output logic              irq
);
  logic [ST_W-1:0] stat_q, stat_nxt;
  logic unused_wd;
  assign unused_wd = ^cfg_wdata;

  always_comb begin
    stat_nxt = stat_q;
    if (cfg_we && cfg_addr == REG_STATUS) stat_nxt = stat_q & ~cfg_wdata[ST_W-1:0];
    if (tx_done_i) stat_nxt[ST_TXC]  = 1'b1;
    if (tx_bu_i)   stat_nxt[ST_TXBU] = 1'b1;
    if (rx_done_i) stat_nxt[ST_RXC]  = 1'b1;
    if (rx_bu_i)   stat_nxt[ST_RXBU] = 1'b1;
    if (tx_done_i || rx_done_i) stat_nxt[ST_SUM] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_base <= '0; tx_size <= '0; rx_base <= '0; rx_size <= '0;
      rx_buf  <= LEN_W'(DEF_BUF);
      tx_kick <= 1'b0; rx_kick <= 1'b0;
      stat_q  <= '0;
      cfg_rdata <= '0;
    end else begin
      tx_kick <= cfg_we && cfg_addr == REG_TX_KICK;
      rx_kick <= cfg_we && cfg_addr == REG_RX_KICK;
      stat_q  <= stat_nxt;
      if (cfg_we) begin
        case (cfg_addr)
          REG_TX_BASE: tx_base <= cfg_wdata[ADDR_W-1:0];
          REG_TX_SIZE: tx_size <= cfg_wdata[IDX_W-1:0];
          REG_RX_BASE: rx_base <= cfg_wdata[ADDR_W-1:0];
          REG_RX_SIZE: rx_size <= cfg_wdata[IDX_W-1:0];
          REG_RX_BUF:  rx_buf  <= cfg_wdata[LEN_W-1:0];
          default: ;
        endcase
      end
      case (cfg_addr)
        REG_TX_BASE: cfg_rdata <= 32'(tx_base);
        REG_TX_SIZE: cfg_rdata <= 32'(tx_size);
        REG_RX_BASE: cfg_rdata <= 32'(rx_base);
        REG_RX_SIZE: cfg_rdata <= 32'(rx_size);
        REG_STATUS:  cfg_rdata <= 32'(stat_q);
        REG_RX_BUF:  cfg_rdata <= 32'(rx_buf);
        default:     cfg_rdata <= '0;
      endcase
    end
  end

  assign irq = stat_q[ST_SUM];

  assert_done_sets_summary_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_done_i || rx_done_i) |=> stat_q[ST_SUM]);
  assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == REG_STATUS && cfg_wdata[ST_TXC] && !tx_done_i) |=> !stat_q[ST_TXC]);
endmodule

// File: rtl/dma_tx_engine.sv
`timescale 1ns/1ps
module dma_tx_engine
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  last_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              done_o,
  output logic              bu_o
);
  tx_st_t            state;
  logic [31:0]       ctl_w;
  logic [31:0]       wbuf;
  logic [ADDR_W-1:0] bptr;
  logic [LEN_W-1:0]  remain;
  logic [1:0]        lane;
  logic              ioc;
  logic              adv;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] desc_addr;

  assign adv = (state == T_WB);

  dma_ring_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .adv(adv), .last_idx(last_idx), .base(base),
    .idx(idx), .desc_addr(desc_addr)
  );

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = desc_addr; mem_wdata = '0;
    case (state)
      T_RD3: begin mem_req = 1'b1; mem_addr = desc_addr + ADDR_W'(3); end
      T_CK3: begin mem_req = mem_rdata[OWN_BIT]; mem_addr = desc_addr; end
      T_CK0: begin mem_req = 1'b1; mem_addr = desc_addr + ADDR_W'(2); end
      T_RDB: begin mem_req = 1'b1; mem_addr = bptr; end
      T_WB: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr + ADDR_W'(3);
        mem_wdata = ctl_w;
        mem_wdata[OWN_BIT] = 1'b0;
      end
      default: ;
    endcase
  end

  assign tx_valid = (state == T_SEND);
  assign tx_data  = wbuf[{lane, 3'b000} +: 8];
  assign tx_last  = (remain == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= T_IDLE; ctl_w <= '0; wbuf <= '0; bptr <= '0;
      remain <= '0; lane <= '0; ioc <= 1'b0; done_o <= 1'b0; bu_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      bu_o   <= 1'b0;
      case (state)
        T_IDLE: if (kick) state <= T_RD3;
        T_RD3: state <= T_CK3;
        T_CK3: begin
          ctl_w <= mem_rdata;
          if (mem_rdata[OWN_BIT]) state <= T_CK0;
          else begin bu_o <= 1'b1; state <= T_IDLE; end
        end
        T_CK0: begin bptr <= mem_rdata[ADDR_W-1:0]; state <= T_CK2; end
        T_CK2: begin
          remain <= mem_rdata[LEN_W-1:0];
          ioc    <= mem_rdata[IOC_BIT];
          lane   <= '0;
          state  <= (mem_rdata[LEN_W-1:0] == '0) ? T_WB : T_RDB;
        end
        T_RDB: state <= T_CKB;
        T_CKB: begin wbuf <= mem_rdata; state <= T_SEND; end
        T_SEND: if (tx_ready) begin
          remain <= remain - LEN_W'(1);
          lane   <= lane + 2'd1;
          if (remain == LEN_W'(1)) state <= T_WB;
          else if (lane == 2'd3) begin
            bptr  <= bptr + ADDR_W'(1);
            state <= T_RDB;
          end
        end
        T_WB: begin done_o <= ioc; state <= T_RD3; end
        default: state <= T_IDLE;
      endcase
    end
  end

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  assert_tx_parked_R6: assert property (@(posedge clk) disable iff (rst)
    bu_o |-> (!tx_valid && !mem_req));
endmodule

// File: rtl/dma_rx_engine.sv
`timescale 1ns/1ps
module dma_rx_engine
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [LEN_W-1:0]  buf_bytes,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              done_o,
  output logic              bu_o
);
  rx_st_t            state;
  logic [ADDR_W-1:0] bptr;
  logic [LEN_W-1:0]  plen;
  logic [31:0]       pack;
  logic              trunc, pend, end_seen;
  logic              adv, stored;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] desc_addr;
  logic [31:0]       stat_word;
  logic              unused_rd;

  assign unused_rd = ^mem_rdata;
  assign adv      = (state == R_WB);
  assign rx_ready = (state == R_RECV);
  assign stored   = (plen < buf_bytes);

  dma_ring_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .adv(adv), .last_idx(last_idx), .base(base),
    .idx(idx), .desc_addr(desc_addr)
  );

  always_comb begin
    stat_word = '0;
    stat_word[FIRST_BIT] = 1'b1;
    stat_word[LAST_BIT]  = 1'b1;
    stat_word[ERR_BIT]   = trunc;
    stat_word[LEN_W-1:0] = plen;
  end

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = desc_addr; mem_wdata = '0;
    case (state)
      R_RD3: begin mem_req = 1'b1; mem_addr = desc_addr + ADDR_W'(3); end
      R_CK3: begin mem_req = mem_rdata[OWN_BIT]; mem_addr = desc_addr; end
      R_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = bptr + ADDR_W'((plen - LEN_W'(1)) >> 2);
        mem_wdata = pack;
      end
      R_WB: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr + ADDR_W'(3);
        mem_wdata = stat_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= R_IDLE; bptr <= '0; plen <= '0; pack <= '0;
      trunc <= 1'b0; pend <= 1'b0; end_seen <= 1'b0;
      done_o <= 1'b0; bu_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      bu_o   <= 1'b0;
      case (state)
        R_IDLE: if (kick) state <= R_RD3;
        R_RD3: state <= R_CK3;
        R_CK3: begin
          if (mem_rdata[OWN_BIT]) state <= R_CK0;
          else begin bu_o <= 1'b1; state <= R_IDLE; end
        end
        R_CK0: begin
          bptr <= mem_rdata[ADDR_W-1:0];
          plen <= '0; trunc <= 1'b0; pack <= '0; pend <= 1'b0;
          state <= R_RECV;
        end
        R_RECV: if (rx_valid) begin
          end_seen <= rx_last;
          if (stored) begin
            pack[{plen[1:0], 3'b000} +: 8] <= rx_data;
            plen <= plen + LEN_W'(1);
            pend <= 1'b1;
          end else begin
            trunc <= 1'b1;
          end
          if ((stored && plen[1:0] == 2'd3) || (rx_last && (pend || stored)))
            state <= R_WR;
          else if (rx_last)
            state <= R_WB;
        end
        R_WR: begin
          pack <= '0; pend <= 1'b0;
          state <= end_seen ? R_WB : R_RECV;
        end
        R_WB: begin done_o <= 1'b1; state <= R_RD3; end
        default: state <= R_IDLE;
      endcase
    end
  end

  assert_store_in_buffer_R9: assert property (@(posedge clk) disable iff (rst)
    (state == R_WR) |-> (plen != '0 && plen <= buf_bytes));
  assert_last_drops_ready_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready && rx_last) |=> !rx_ready);
endmodule

// File: rtl/dma_ring_engine.sv
`timescale 1ns/1ps
module dma_ring_engine #(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 8,
  parameter int LEN_W   = 14,
  parameter int DEF_BUF = 1536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              irq,
  output logic              txm_req,
  output logic              txm_we,
  output logic [ADDR_W-1:0] txm_addr,
  output logic [31:0]       txm_wdata,
  input  logic [31:0]       txm_rdata,
  output logic              rxm_req,
  output logic              rxm_we,
  output logic [ADDR_W-1:0] rxm_addr,
  output logic [31:0]       rxm_wdata,
  input  logic [31:0]       rxm_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last
);
  logic [ADDR_W-1:0] tx_base, rx_base;
  logic [IDX_W-1:0]  tx_size, rx_size;
  logic [LEN_W-1:0]  rx_buf;
  logic tx_kick, rx_kick, tx_done, tx_bu, rx_done, rx_bu;

  dma_ring_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .DEF_BUF(DEF_BUF)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_base(tx_base), .tx_size(tx_size), .tx_kick(tx_kick),
    .rx_base(rx_base), .rx_size(rx_size), .rx_kick(rx_kick), .rx_buf(rx_buf),
    .tx_done_i(tx_done), .tx_bu_i(tx_bu), .rx_done_i(rx_done), .rx_bu_i(rx_bu), .irq(irq)
  );

  dma_tx_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst), .kick(tx_kick), .base(tx_base), .last_idx(tx_size),
    .mem_req(txm_req), .mem_we(txm_we), .mem_addr(txm_addr), .mem_wdata(txm_wdata),
    .mem_rdata(txm_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .done_o(tx_done), .bu_o(tx_bu)
  );

  dma_rx_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst(rst), .kick(rx_kick), .base(rx_base), .last_idx(rx_size),
    .buf_bytes(rx_buf), .mem_req(rxm_req), .mem_we(rxm_we), .mem_addr(rxm_addr),
    .mem_wdata(rxm_wdata), .mem_rdata(rxm_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .done_o(rx_done), .bu_o(rx_bu)
  );
endmodule

// File: tb/dma_ring_engine_test.sv
`timescale 1ns/1ps
module dma_ring_engine_test;
  localparam int AW = 12;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic irq;
  logic txm_req, txm_we, rxm_req, rxm_we;
  logic [AW-1:0] txm_addr, rxm_addr;
  logic [31:0] txm_wdata, rxm_wdata, txm_rdata, rxm_rdata;
  logic tx_valid, tx_last, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [8:0] expq[$];
  logic [31:0] mem [0:4095];

  always #2.5 clk = ~clk;

  dma_ring_engine #(.ADDR_W(AW), .IDX_W(3), .LEN_W(14)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq),
    .txm_req(txm_req), .txm_we(txm_we), .txm_addr(txm_addr), .txm_wdata(txm_wdata), .txm_rdata(txm_rdata),
    .rxm_req(rxm_req), .rxm_we(rxm_we), .rxm_addr(rxm_addr), .rxm_wdata(rxm_wdata), .rxm_rdata(rxm_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last)
  );

  // memory model, one-cycle read latency per port
  always @(posedge clk) begin
    if (txm_req && txm_we) mem[txm_addr] <= txm_wdata;
    if (txm_req && !txm_we) txm_rdata <= mem[txm_addr];
    if (rxm_req && rxm_we) mem[rxm_addr] <= rxm_wdata;
    if (rxm_req && !rxm_we) rxm_rdata <= mem[rxm_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tx_ready <= (cyc % 3) != 2;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard for the transmit stream, plus hold check under stall
  logic prev_stall = 1'b0;
  logic [8:0] prev_beat = '0;
  always @(negedge clk) begin
    if (prev_stall) chk("R12 hold under stall", {23'd0, tx_valid, tx_last, tx_data}, {23'd0, 1'b1, prev_beat});
    if (tx_valid && tx_ready) begin
      if (expq.size() == 0) chk("R3 unexpected byte", {23'd0, tx_last, tx_data}, 32'h1ff);
      else chk("R3 byte", {23'd0, tx_last, tx_data}, {23'd0, expq.pop_front()});
    end
    prev_stall = tx_valid && !tx_ready;
    prev_beat  = {tx_last, tx_data};
  end

  task automatic cfg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic wait_stat(int b);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      cfg_rd(3'd6, s);
      if (s[b]) break;
    end
  endtask

  function automatic logic [7:0] txb(int d, int k);
    return 8'(16 * d + k);
  endfunction

  // driver: builds a transmit descriptor and pushes the expected bytes
  task automatic tx_desc(int d, int len, bit ioc);
    int buf_a = 12'h200 + 16 * d;
    for (int w = 0; w < 4; w++)
      mem[buf_a + w] = {txb(d, 4*w+3), txb(d, 4*w+2), txb(d, 4*w+1), txb(d, 4*w)};
    mem[12'h100 + 4*d]     = 32'(buf_a);
    mem[12'h100 + 4*d + 2] = {ioc, 17'd0, 14'(len)};
    mem[12'h100 + 4*d + 3] = 32'hB000_0000;
    for (int k = 0; k < len; k++) expq.push_back({(k == len - 1), txb(d, k)});
  endtask

  task automatic rx_frame(logic [7:0] first, int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = first + 8'(k); rx_last = (k == len - 1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cfg_rd(3'd6, s);
    chk("R1 status after reset", s, 32'h0);
    chk("R1 outputs after reset", {29'd0, irq, tx_valid, rx_ready}, 32'h0);

    // run 1: four-entry ring, walk and wrap
    cfg_wr(3'd0, 32'h100);
    cfg_wr(3'd1, 32'd3);
    tx_desc(0, 5, 1'b1); tx_desc(1, 8, 1'b0); tx_desc(2, 1, 1'b1); tx_desc(3, 3, 1'b1);
    cfg_wr(3'd2, 32'h0);
    wait_stat(1);
    chk("R3 all bytes sent", 32'(expq.size()), 32'd0);
    for (int d = 0; d < 4; d++) chk("R4 write-back clears ownership", mem[12'h100 + 4*d + 3], 32'h3000_0000);
    cfg_rd(3'd6, s);
    chk("R6 R10 status after run 1", s, 32'h13);
    chk("R10 irq follows summary", {31'd0, irq}, 32'd1);

    // run 2: wrapped index is 0, no completion flag
    cfg_wr(3'd6, 32'h1F);
    cfg_rd(3'd6, s);
    chk("R10 write-one clears all", s, 32'h0);
    tx_desc(0, 4, 1'b0);
    cfg_wr(3'd2, 32'h1);
    wait_stat(1);
    chk("R2 wrap resumes at descriptor 0", 32'(expq.size()), 32'd0);
    cfg_rd(3'd6, s);
    chk("R5 no complete without IOC", s, 32'h2);
    chk("R4 descriptor 0 returned", mem[12'h103], 32'h3000_0000);

    // run 3: owned descriptor without kick stays untouched
    cfg_wr(3'd6, 32'h2);
    tx_desc(1, 2, 1'b1);
    repeat (40) @(negedge clk);
    chk("R7 no restart without kick", mem[12'h107], 32'hB000_0000);
    cfg_rd(3'd6, s);
    chk("R7 status idle without kick", s, 32'h0);
    cfg_wr(3'd2, 32'hDEAD_BEEF);
    wait_stat(1);
    chk("R7 kick restarts", mem[12'h107], 32'h3000_0000);
    cfg_rd(3'd6, s);
    chk("R5 complete with IOC", s & 32'h1, 32'h1);
    cfg_wr(3'd6, 32'h1);
    cfg_rd(3'd6, s);
    chk("R10 selective clear", s, 32'h12);

    // receive: two-entry ring, six-byte buffers
    cfg_wr(3'd6, 32'h1F);
    cfg_wr(3'd3, 32'h300);
    cfg_wr(3'd4, 32'd1);
    cfg_wr(3'd7, 32'd6);
    for (int w = 0; w < 4; w++) begin mem[12'h400 + w] = '1; mem[12'h410 + w] = '1; end
    mem[12'h300] = 32'h400; mem[12'h303] = 32'h8000_0000;
    mem[12'h304] = 32'h410; mem[12'h307] = 32'h8000_0000;
    repeat (4) @(negedge clk);
    chk("R11 not ready before kick", {31'd0, rx_ready}, 32'd0);
    cfg_wr(3'd5, 32'h0);
    rx_frame(8'h21, 5);
    rx_frame(8'h31, 9);
    wait_stat(3);
    chk("R8 first word", mem[12'h400], 32'h2423_2221);
    chk("R8 partial word zero-filled", mem[12'h401], 32'h0000_0025);
    chk("R8 status write-back", mem[12'h303], 32'h3000_0005);
    chk("R9 truncated words", mem[12'h410], 32'h3433_3231);
    chk("R9 truncated tail", mem[12'h411], 32'h0000_3635);
    chk("R9 nothing past buffer", mem[12'h412], 32'hFFFF_FFFF);
    chk("R9 error and length", mem[12'h307], 32'h3000_8006);
    cfg_rd(3'd6, s);
    chk("R6 R8 receive status", s, 32'h1C);
    chk("R11 not ready when parked", {31'd0, rx_ready}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule